// File: doc/BRIEF.md
# Multi-Agent Exclusive Reservation Monitor

This block keeps one reservation entry per requesting agent for a memory that several agents share. It accepts at most one operation per cycle from a request port that an arbiter outside the block already serializes. Each operation names the issuing agent, an operation code and a byte address. A load-exclusive opens a reservation on an exact address. A plain store from any agent cancels every reservation. A store-exclusive asks whether the issuing agent still holds its reservation. The block answers with a pass or fail verdict.

The requester's own check uses an exact address compare. When a store-exclusive wins, every other agent holding a reservation in the same aligned granule loses it, so the snoop side is deliberately coarse. A per-agent counter turns every (MAX+1)-th exact-match success into a failure, which mimics spurious reservation loss. Software retry loops therefore see their failure paths exercised. A separate drop port removes an agent from tracking and resets its entry.

Top module: `resv_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `verdictValid` and `verdictPass` are low. Reset leaves every entry unreserved with tag and failure counter at zero.
- R2: `reqOp` = 0 (load-exclusive) reserves the full `reqAddr` for `reqAgent`. A later load-exclusive from the same agent replaces the reserved address.
- R3: `reqOp` = 2 (store-exclusive) can pass only if the issuing agent holds a reservation whose address equals `reqAddr` in every bit. It fails when the agent holds no reservation or the address differs. Every store-exclusive leaves the issuing agent unreserved, whatever its verdict.
- R4: `reqOp` = 1 (plain store) from any agent removes every agent's reservation, whatever the address.
- R5: A passing store-exclusive removes the reservation of each other agent whose reserved address lies in the same aligned granule of `GRAN_BYTES` bytes (equal `addr / GRAN_BYTES`). Reservations in other granules stay intact.
- R6: Each agent counts its exact-match store-exclusives since reset or since it was last dropped. Attempt number k fails when k is a multiple of `FAIL_PERIOD_MAX`+1, and otherwise passes. Such a forced failure removes no other agent's reservation.
- R7: `dropValid` high removes `dropAgent` from tracking. That agent's reservation is cleared and its failure counter returns to zero. If the same agent issues a request in that cycle, the drop takes precedence for its entry.
- R8: `verdictValid` is high for exactly the one cycle after each accepted store-exclusive and low in every other cycle. `verdictPass` is low whenever `verdictValid` is low.
- R9: `reqOp` = 3 changes no entry and produces no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| reqAgent | input | AGENT_W | Issuing agent index |
| reqOp | input | 2 | 0 load-exclusive, 1 plain store, 2 store-exclusive, 3 no-op |
| reqAddr | input | ADDR_W | Byte address of the access |
| dropValid | input | 1 | Remove an agent from tracking |
| dropAgent | input | AGENT_W | Agent to remove |
| verdictValid | output | 1 | Store-exclusive verdict present |
| verdictPass | output | 1 | 1 = store-exclusive succeeded |

## Verification
The hardest state to reach is the forced failure that coincides with a second agent holding a reservation in the same granule. Reaching it needs the first agent's counter to sit exactly at its maximum. The second agent's reservation must be armed before that attempt, and the second agent's own store-exclusive must be observed afterwards. The bench drives FAIL_PERIOD_MAX clean reserve-and-commit pairs first, then arms both agents, and only then fires the forced attempt. A granule sweep moves the second address through both sides of the granule boundary under rotating requesters, so that exact and coarse comparisons are told apart.

// File: rtl/resv_monitor_pkg.sv
package resv_monitor_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_EX  = 2'd0,
    OP_STORE    = 2'd1,
    OP_STORE_EX = 2'd2,
    OP_IDLE     = 2'd3
  } monOp_e;

  // One-hot decoded operation handed from control to the entry array
  typedef struct packed {
    logic loadEx;
    logic store;
    logic storeEx;
  } monStrobe_t;

endpackage

// File: rtl/resv_monitor_ctrl.sv
module resv_monitor_ctrl
  import resv_monitor_pkg::*;
#(
  parameter int NUM_AGENTS = 4,
  parameter int AGENT_W    = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  input  logic [AGENT_W-1:0]    reqAgent,
  input  logic [1:0]            reqOp,
  input  logic                  dropValid,
  input  logic [AGENT_W-1:0]    dropAgent,
  input  logic                  grantPass,
  output monStrobe_t            strobe,
  output logic [NUM_AGENTS-1:0] reqSel,
  output logic [NUM_AGENTS-1:0] dropSel,
  output logic                  verdictValid,
  output logic                  verdictPass
);

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      unique case (monOp_e'(reqOp))
        OP_LOAD_EX:  strobe.loadEx  = 1'b1;
        OP_STORE:    strobe.store   = 1'b1;
        OP_STORE_EX: strobe.storeEx = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_sel
    assign reqSel[i]  = (reqAgent  == AGENT_W'(i));
    assign dropSel[i] = dropValid && (dropAgent == AGENT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      verdictValid <= 1'b0;
      verdictPass  <= 1'b0;
    end else begin
      verdictValid <= strobe.storeEx;
      verdictPass  <= strobe.storeEx && grantPass;
    end
  end

endmodule

// File: rtl/resv_monitor_entries.sv
module resv_monitor_entries
  import resv_monitor_pkg::*;
#(
  parameter int NUM_AGENTS      = 4,
  parameter int ADDR_W          = 16,
  parameter int GRAN_BYTES      = 64,
  parameter int FAIL_PERIOD_MAX = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  monStrobe_t            strobe,
  input  logic [NUM_AGENTS-1:0] reqSel,
  input  logic [NUM_AGENTS-1:0] dropSel,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  grantPass
);

  localparam int GRAN_LOG2 = $clog2(GRAN_BYTES);
  localparam int CNT_W     = $clog2(FAIL_PERIOD_MAX + 1);
  localparam logic [ADDR_W-1:0] GRAN_MASK = {ADDR_W{1'b1}} << GRAN_LOG2;

  logic                  isExcl   [NUM_AGENTS];
  logic                  isMember [NUM_AGENTS];
  logic [ADDR_W-1:0]     tagAddr  [NUM_AGENTS];
  logic [CNT_W-1:0]      failCnt  [NUM_AGENTS];

  logic [NUM_AGENTS-1:0] exactHit;
  logic [NUM_AGENTS-1:0] forcedFail;
  logic [NUM_AGENTS-1:0] passVec;
  logic [NUM_AGENTS-1:0] snoopHit;
  logic                  anyPass;

  assign anyPass   = |passVec;
  assign grantPass = anyPass;

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_entry
    assign exactHit[i]   = strobe.storeEx && reqSel[i] && isExcl[i] &&
                           (tagAddr[i] == reqAddr);
    assign forcedFail[i] = exactHit[i] && (failCnt[i] >= CNT_W'(FAIL_PERIOD_MAX));
    assign passVec[i]    = exactHit[i] && !forcedFail[i];
    assign snoopHit[i]   = !reqSel[i] && isMember[i] && isExcl[i] &&
                           ((tagAddr[i] & GRAN_MASK) == (reqAddr & GRAN_MASK));

    always_ff @(posedge clk) begin
      if (rst || dropSel[i]) begin
        isExcl[i]   <= 1'b0;
        isMember[i] <= 1'b0;
        tagAddr[i]  <= '0;
        failCnt[i]  <= '0;
      end else begin
        if (strobe.loadEx && reqSel[i]) begin
          isExcl[i]   <= 1'b1;
          isMember[i] <= 1'b1;
          tagAddr[i]  <= reqAddr;
        end
        if (strobe.store && isMember[i]) begin
          isExcl[i]  <= 1'b0;
          tagAddr[i] <= '0;
        end
        if (strobe.storeEx && reqSel[i]) begin
          isExcl[i]  <= 1'b0;
          tagAddr[i] <= '0;
          if (exactHit[i]) begin
            failCnt[i] <= forcedFail[i] ? '0 : failCnt[i] + 1'b1;
          end
        end
        if (strobe.storeEx && anyPass && snoopHit[i]) begin
          isExcl[i]  <= 1'b0;
          tagAddr[i] <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_monitor_pkg::*;
#(
  parameter int NUM_AGENTS      = 4,
  parameter int ADDR_W          = 16,
  parameter int GRAN_BYTES      = 64,
  parameter int FAIL_PERIOD_MAX = 15,
  parameter int AGENT_W         = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [AGENT_W-1:0] reqAgent,
  input  logic [1:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               dropValid,
  input  logic [AGENT_W-1:0] dropAgent,
  output logic               verdictValid,
  output logic               verdictPass
);

  monStrobe_t            strobe;
  logic [NUM_AGENTS-1:0] reqSel;
  logic [NUM_AGENTS-1:0] dropSel;
  logic                  grantPass;

  resv_monitor_ctrl #(
    .NUM_AGENTS(NUM_AGENTS),
    .AGENT_W   (AGENT_W)
  ) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .reqAgent    (reqAgent),
    .reqOp       (reqOp),
    .dropValid   (dropValid),
    .dropAgent   (dropAgent),
    .grantPass   (grantPass),
    .strobe      (strobe),
    .reqSel      (reqSel),
    .dropSel     (dropSel),
    .verdictValid(verdictValid),
    .verdictPass (verdictPass)
  );

  resv_monitor_entries #(
    .NUM_AGENTS     (NUM_AGENTS),
    .ADDR_W         (ADDR_W),
    .GRAN_BYTES     (GRAN_BYTES),
    .FAIL_PERIOD_MAX(FAIL_PERIOD_MAX)
  ) i_entries (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .reqSel   (reqSel),
    .dropSel  (dropSel),
    .reqAddr  (reqAddr),
    .grantPass(grantPass)
  );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int AGENT_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic [AGENT_W-1:0] reqAgent,
  input logic [1:0]         reqOp,
  input logic               dropValid,
  input logic [AGENT_W-1:0] dropAgent,
  input logic               verdictValid,
  input logic               verdictPass
);

  logic               stexNow;
  logic               prevStore;
  logic               prevStex;
  logic [AGENT_W-1:0] prevStexAgent;
  logic               prevDrop;
  logic [AGENT_W-1:0] prevDropAgent;

  assign stexNow = reqValid && (reqOp == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevStore     <= 1'b0;
      prevStex      <= 1'b0;
      prevStexAgent <= '0;
      prevDrop      <= 1'b0;
      prevDropAgent <= '0;
    end else begin
      prevStore     <= reqValid && (reqOp == 2'd1);
      prevStex      <= stexNow;
      prevStexAgent <= reqAgent;
      prevDrop      <= dropValid;
      prevDropAgent <= dropAgent;
    end
  end

  assert_verdict_follows_R8: assert property (@(posedge clk) disable iff (rst)
    stexNow |=> verdictValid);

  assert_no_stray_verdict_R8: assert property (@(posedge clk) disable iff (rst)
    !stexNow |=> !verdictValid);

  assert_pass_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !verdictValid |-> !verdictPass);

  assert_store_kills_all_R4: assert property (@(posedge clk) disable iff (rst)
    (prevStore && stexNow) |=> !verdictPass);

  assert_stex_consumes_R3: assert property (@(posedge clk) disable iff (rst)
    (prevStex && stexNow && (reqAgent == prevStexAgent)) |=> !verdictPass);

  assert_drop_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (prevDrop && stexNow && (reqAgent == prevDropAgent)) |=> !verdictPass);

endmodule

bind resv_monitor resv_monitor_chk #(.AGENT_W(AGENT_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .reqValid    (reqValid),
  .reqAgent    (reqAgent),
  .reqOp       (reqOp),
  .dropValid   (dropValid),
  .dropAgent   (dropAgent),
  .verdictValid(verdictValid),
  .verdictPass (verdictPass)
);

// File: tb/test_resv_monitor.sv
module test_resv_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_AGENTS = 4;
  localparam int ADDR_W     = 16;
  localparam int GRAN_BYTES = 64;
  localparam int FAIL_MAX   = 15;
  localparam int AGENT_W    = 2;

  localparam logic [1:0] LDEX = 2'd0;
  localparam logic [1:0] STOR = 2'd1;
  localparam logic [1:0] STEX = 2'd2;
  localparam logic [1:0] NOOP = 2'd3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               reqValid = 1'b0;
  logic [AGENT_W-1:0] reqAgent = '0;
  logic [1:0]         reqOp = '0;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic               dropValid = 1'b0;
  logic [AGENT_W-1:0] dropAgent = '0;
  logic               verdictValid;
  logic               verdictPass;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor #(
    .NUM_AGENTS     (NUM_AGENTS),
    .ADDR_W         (ADDR_W),
    .GRAN_BYTES     (GRAN_BYTES),
    .FAIL_PERIOD_MAX(FAIL_MAX)
  ) i_resv_monitor (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAgent(reqAgent),
    .reqOp(reqOp), .reqAddr(reqAddr), .dropValid(dropValid),
    .dropAgent(dropAgent), .verdictValid(verdictValid), .verdictPass(verdictPass)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 verdictValid in reset", verdictValid, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 verdictPass after reset", verdictPass, 0);
  endtask

  // Drive one request; outputs sampled just after the edge that registers it
  task automatic send(input int ag, input logic [1:0] op, input int addr);
    @(negedge clk);
    reqValid = 1'b1;
    reqAgent = AGENT_W'(ag);
    reqOp    = op;
    reqAddr  = ADDR_W'(addr);
    @(posedge clk);
    #1;
    reqValid = 1'b0;
  endtask

  task automatic stex(input string tag, input int ag, input int addr, input int expPass);
    send(ag, STEX, addr);
    chk({tag, " valid"}, verdictValid, 1);
    chk(tag, verdictPass, expPass);
  endtask

  task automatic drop(input int ag);
    @(negedge clk);
    dropValid = 1'b1;
    dropAgent = AGENT_W'(ag);
    @(posedge clk);
    #1;
    dropValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    doReset();

    // R2 / R8: load-exclusive gives no verdict, exact store-exclusive passes
    send(0, LDEX, 'h1234);
    chk("R8 no verdict after load-exclusive", verdictValid, 0);
    stex("R3 exact match passes", 0, 'h1234, 1);
    @(posedge clk); #1;
    chk("R8 verdict lasts one cycle", verdictValid, 0);

    // R3: no reservation, then mismatch consumes entry
    stex("R3 open entry fails", 1, 'h0100, 0);
    send(1, LDEX, 'h0100);
    stex("R3 address mismatch fails", 1, 'h0104, 0);
    stex("R3 entry cleared by failing attempt", 1, 'h0100, 0);

    // R2: re-reserve replaces address
    send(2, LDEX, 'h0400);
    send(2, LDEX, 'h0800);
    stex("R2 old address dropped", 2, 'h0400, 0);
    send(2, LDEX, 'h0400);
    send(2, LDEX, 'h0800);
    stex("R2 new address held", 2, 'h0800, 1);

    // R4: plain store elsewhere clears all
    send(0, LDEX, 'h2000);
    send(3, LDEX, 'h3000);
    send(1, STOR, 'h7FC0);
    stex("R4 store clears agent0", 0, 'h2000, 0);
    stex("R4 store clears agent3", 3, 'h3000, 0);

    // R9: no-op leaves reservation
    send(1, LDEX, 'h0500);
    send(0, NOOP, 'h0500);
    chk("R9 no verdict for no-op", verdictValid, 0);
    stex("R9 no-op harmless", 1, 'h0500, 1);

    // R5: granule sweep, reset per step so counters stay low
    for (int d = 0; d < 160; d += 8) begin
      int a = 'h1044;
      int b = 'h1000 + d;
      int r = (d / 8) % NUM_AGENTS;
      int s = (r + 1) % NUM_AGENTS;
      doReset();
      send(r, LDEX, a);
      send(s, LDEX, b);
      stex("R5 requester passes", r, a, 1);
      stex("R5 other agent by granule", s, b, ((a / GRAN_BYTES) != (b / GRAN_BYTES)) ? 1 : 0);
    end

    // R6: periodic forced failure
    doReset();
    for (int k = 1; k <= 2 * (FAIL_MAX + 1); k++) begin
      send(3, LDEX, 'h0200);
      stex("R6 failure cadence", 3, 'h0200, ((k % (FAIL_MAX + 1)) == 0) ? 0 : 1);
    end

    // R6: forced failure does not snoop other agents
    doReset();
    for (int k = 0; k < FAIL_MAX; k++) begin
      send(0, LDEX, 'h0300);
      send(0, STEX, 'h0300);
    end
    send(1, LDEX, 'h0308);
    send(0, LDEX, 'h0300);
    stex("R6 forced failure", 0, 'h0300, 0);
    stex("R6 forced failure spares neighbour", 1, 'h0308, 1);

    // R7: drop clears reservation and counter
    doReset();
    send(2, LDEX, 'h0600);
    drop(2);
    stex("R7 drop clears reservation", 2, 'h0600, 0);
    for (int k = 0; k < FAIL_MAX; k++) begin
      send(2, LDEX, 'h0600);
      send(2, STEX, 'h0600);
    end
    drop(2);
    send(2, LDEX, 'h0600);
    stex("R7 drop resets counter", 2, 'h0600, 1);

    // R7: drop in the same cycle as a load-exclusive wins
    @(negedge clk);
    reqValid = 1'b1; reqAgent = 2'd1; reqOp = LDEX; reqAddr = 'h0700;
    dropValid = 1'b1; dropAgent = 2'd1;
    @(posedge clk); #1;
    reqValid = 1'b0; dropValid = 1'b0;
    stex("R7 drop beats same-cycle reserve", 1, 'h0700, 0);

    finishRun();
  end

endmodule